// File: doc/BRIEF.md
# Dual-Space Data Memory Addressing Unit

This block is the on-chip data store of an 8-bit microcontroller core. One 8-bit address space is shared by two kinds of storage: a 256-byte RAM and a bank of special function registers (SFRs) in the upper half of the space. The addressing mode of an access decides where an address in the upper half lands. A direct byte access there reaches an SFR. A register-indirect byte access there reaches the upper RAM. A single-bit access reaches a small bit-addressable window of RAM, or one of the bit-addressable SFRs.

The core presents a mode code, an 8-bit address, write data, a single bit value and a write strobe. Reads are combinational from the current contents. A write lands on the rising clock edge. A bit write is a read-modify-write of the addressed byte, done in the same cycle. The core supplies indirect pointers already resolved into `acc_addr`. The peripherals behind the SFRs are not part of this block.

Top module: `dsu_top`

## Requirements
- R1: Each access resolves to at most one target: a RAM byte, an SFR, or nothing. `rd_data` is the current value of that target, or 00h when there is no target. The mode codes on `acc_mode` are 0 direct, 1 indirect, 2 bit and 3 reserved.
- R2: A direct access (mode 0) to an address from 00h to 7Fh reads and writes the RAM byte at that same index.
- R3: A direct access to an address from 80h to FFh reaches the SFR at that address. It never changes RAM.
- R4: An indirect access (mode 1) reaches RAM byte `acc_addr` for every address from 00h to FFh. It never reads or changes an SFR.
- R5: In bit mode (mode 2), `acc_addr[2:0]` selects the bit and the upper five bits select the byte. `rd_bit` equals that bit of the byte. `rd_data` carries the whole byte. `rd_bit` is 0 in every other mode.
- R6: A bit address from 00h to 7Fh selects RAM byte 20h + `acc_addr[6:3]`. Only RAM bytes 20h to 2Fh can be reached this way.
- R7: A bit write sets the selected bit to `bit_in` and leaves the other seven bits of the byte unchanged.
- R8: A bit address from 80h to FFh selects the SFR at `{acc_addr[7:3],3'b000}`. The bit-addressable SFRs are exactly the 13 addresses of the form xxxxx000b from 80h to F8h, excluding C0h, D8h and E8h.
- R9: The implemented SFRs are those 13 plus the 14 byte-only addresses 81h–87h and 89h–8Fh. Any other SFR address reads as 00h in direct and bit mode, and writes to it are ignored.
- R10: Writes take effect at the rising clock edge, and a read made before that edge returns the old value. A synchronous `rst` clears every SFR to 00h. RAM contents are not defined by reset.
- R11: Mode 3 has no target. It reads 00h with `rd_bit` 0, and it changes neither RAM nor any SFR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the SFRs |
| acc_mode | input | 2 | Addressing mode: 0 direct, 1 indirect, 2 bit, 3 reserved |
| acc_addr | input | 8 | Byte address, or bit address in bit mode |
| wr_data | input | 8 | Byte written in direct and indirect mode |
| bit_in | input | 1 | Bit value written in bit mode |
| wr_en | input | 1 | Write strobe for the current access |
| rd_data | output | 8 | Current value of the target byte |
| rd_bit | output | 1 | Selected bit of the target byte in bit mode |

## Verification
The hardest situation to reach is the aliasing of the upper half. A store to address A through one mode must leave the storage behind A in the other mode untouched. Bit writes must also keep the seven neighbouring bits of the same byte. The bench first fills all 256 RAM bytes indirectly and all 128 upper addresses directly, with two distinct arithmetic patterns. Every later access can then be compared against both patterns, so an access that lands in the wrong space shows up as a wrong value. It then sweeps all 256 bit addresses. Each bit is read, inverted with a bit write, and the whole byte is read back through the byte path of its own space.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BIT_W  = 3;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_BIT      = 2'd2,
    AM_RSVD     = 2'd3
  } amode_e;

  // SFR that accepts bit access: row start, minus three unpopulated rows
  function automatic logic sfr_bitable(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] && (a[BIT_W-1:0] == '0) &&
           (a != 8'hC0) && (a != 8'hD8) && (a != 8'hE8);
  endfunction

  // SFR reachable only as a whole byte: the first row of the space
  function automatic logic sfr_byte_only(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:4] == 4'h8) && (a[BIT_W-1:0] != '0);
  endfunction

  function automatic logic sfr_exists(input logic [ADDR_W-1:0] a);
    return sfr_bitable(a) || sfr_byte_only(a);
  endfunction

  function automatic logic [ADDR_W-1:0] bit_ram_byte(input logic [ADDR_W-1:0] a,
                                                     input logic [ADDR_W-1:0] base);
    return base + ADDR_W'(a[ADDR_W-2:BIT_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] bit_sfr_byte(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:BIT_W], {BIT_W{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] bit_merge(input logic [DATA_W-1:0] old,
                                                  input logic [BIT_W-1:0] idx,
                                                  input logic val);
    logic [DATA_W-1:0] r;
    r = old;
    r[idx] = val;
    return r;
  endfunction
endpackage

// File: rtl/dsu_addr_resolve.sv
module dsu_addr_resolve
  import dsu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20
) (
  input  logic [1:0]        acc_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              ram_sel,
  output logic              sfr_sel,
  output logic              is_bit,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [BIT_W-1:0]  bit_idx
);
  always_comb begin
    ram_sel  = 1'b0;
    sfr_sel  = 1'b0;
    is_bit   = 1'b0;
    tgt_addr = acc_addr;
    bit_idx  = acc_addr[BIT_W-1:0];
    case (amode_e'(acc_mode))
      AM_DIRECT: begin
        if (acc_addr[ADDR_W-1]) sfr_sel = 1'b1;
        else                    ram_sel = 1'b1;
      end
      AM_INDIRECT: ram_sel = 1'b1;
      AM_BIT: begin
        is_bit = 1'b1;
        if (acc_addr[ADDR_W-1]) begin
          sfr_sel  = 1'b1;
          tgt_addr = bit_sfr_byte(acc_addr);
        end else begin
          ram_sel  = 1'b1;
          tgt_addr = bit_ram_byte(acc_addr, BIT_RAM_BASE);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dsu_ram.sv
module dsu_ram
  import dsu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dsu_sfr_bank.sv
module dsu_sfr_bank
  import dsu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          hit
);
  localparam int NSLOT = 1 << (AW - 1);

  logic [DW-1:0] slot_q [NSLOT];
  logic          any_set;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [AW-1:0] SLOT_ADDR = AW'(NSLOT + i);
    if (sfr_exists(SLOT_ADDR)) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                            q <= '0;
        else if (we && addr == SLOT_ADDR)   q <= wdata;
      end
      assign slot_q[i] = q;
    end else begin : g_hole
      assign slot_q[i] = '0;
    end
  end

  assign hit   = addr[AW-1] && sfr_exists(addr);
  assign rdata = addr[AW-1] ? slot_q[addr[AW-2:0]] : '0;

  always_comb begin
    any_set = 1'b0;
    for (int k = 0; k < NSLOT; k++) any_set = any_set | (|slot_q[k]);
  end

  // R10: one cycle after reset no SFR holds a set bit
  assert_sfr_reset_clear_R10: assert property (@(posedge clk) rst |=> !any_set);

  // R9: an address with no register behind it reads zero
  assert_unimpl_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !hit |-> rdata == '0);
endmodule

// File: rtl/dsu_top.sv
module dsu_top
  import dsu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        acc_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_in,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit
);
  localparam logic [ADDR_W-1:0] BIT_RAM_LAST = BIT_RAM_BASE + ADDR_W'((1 << (ADDR_W - 1 - BIT_W)) - 1);

  logic              ram_sel, sfr_sel, is_bit;
  logic [ADDR_W-1:0] tgt_addr;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] ram_rdata, sfr_rdata, cur_byte, new_byte;
  logic              ram_we, sfr_we, sfr_hit;

  dsu_addr_resolve #(.BIT_RAM_BASE(BIT_RAM_BASE)) u_resolve (
    .acc_mode (acc_mode),
    .acc_addr (acc_addr),
    .ram_sel  (ram_sel),
    .sfr_sel  (sfr_sel),
    .is_bit   (is_bit),
    .tgt_addr (tgt_addr),
    .bit_idx  (bit_idx)
  );

  dsu_ram u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (tgt_addr),
    .wdata (new_byte),
    .rdata (ram_rdata)
  );

  dsu_sfr_bank u_sfr (
    .clk   (clk),
    .rst   (rst),
    .we    (sfr_we),
    .addr  (tgt_addr),
    .wdata (new_byte),
    .rdata (sfr_rdata),
    .hit   (sfr_hit)
  );

  always_comb begin
    if (ram_sel)                 cur_byte = ram_rdata;
    else if (sfr_sel && sfr_hit) cur_byte = sfr_rdata;
    else                         cur_byte = '0;
  end

  assign new_byte = is_bit ? bit_merge(cur_byte, bit_idx, bit_in) : wr_data;
  assign ram_we   = wr_en && ram_sel;
  assign sfr_we   = wr_en && sfr_sel;
  assign rd_data  = cur_byte;
  assign rd_bit   = is_bit && cur_byte[bit_idx];

  // R1: never both storages in one cycle
  assert_single_target_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, sfr_we}));

  // R2: direct low half goes to RAM at the same index
  assert_direct_low_ram_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == AM_DIRECT && !acc_addr[ADDR_W-1]) |-> (ram_sel && tgt_addr == acc_addr));

  // R4: indirect never writes a register
  assert_indirect_no_sfr_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == AM_INDIRECT) |-> !sfr_we);

  // R6: bit writes into RAM stay inside the bit window
  assert_bit_ram_window_R6: assert property (@(posedge clk) disable iff (rst)
    (is_bit && ram_we) |-> (tgt_addr >= BIT_RAM_BASE && tgt_addr <= BIT_RAM_LAST));

  // R7: a bit write differs from the old byte in the chosen bit only
  assert_bit_keeps_others_R7: assert property (@(posedge clk) disable iff (rst)
    (is_bit && ram_we) |-> (((new_byte ^ ram_rdata) & ~(DATA_W'(1) << bit_idx)) == '0));

  // R11: reserved mode writes nothing and reads zero
  assert_rsvd_inert_R11: assert property (@(posedge clk) disable iff (rst)
    (acc_mode == AM_RSVD) |-> (!ram_we && !sfr_we && rd_data == '0));
endmodule

// File: tb/tb_dsu_top.sv
`timescale 1ns/1ps
module tb_dsu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] acc_mode = 2'd0;
  logic [7:0] acc_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       bit_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [256];

  always #2.5 clk = ~clk;

  dsu_top dut (
    .clk(clk), .rst(rst), .acc_mode(acc_mode), .acc_addr(acc_addr),
    .wr_data(wr_data), .bit_in(bit_in), .wr_en(wr_en),
    .rd_data(rd_data), .rd_bit(rd_bit)
  );

  function automatic bit impl(input int a);
    bit bitrow, firstrow;
    bitrow   = (a >= 128) && (a % 8 == 0) && !(a == 192 || a == 216 || a == 232);
    firstrow = (a / 16 == 8) && (a % 8 != 0);
    return bitrow || firstrow;
  endfunction

  function automatic logic [7:0] pat_ram(input int a);
    return 8'((a * 7 + 3) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] pat_sfr(input int a);
    return 8'(~(a * 3) + 1);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input int m, input int a);
    @(negedge clk);
    acc_mode = 2'(m); acc_addr = 8'(a); wr_en = 1'b0;
    #1;
  endtask

  task automatic wr(input int m, input int a, input logic [7:0] d, input logic b);
    @(negedge clk);
    acc_mode = 2'(m); acc_addr = 8'(a); wr_data = d; bit_in = b; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) sfr_m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10: registers read zero after reset
    for (int a = 128; a < 256; a++) begin
      rd(0, a); check("R10 reset", rd_data, 8'h00);
    end

    // R4: fill and read back the whole RAM indirectly
    for (int a = 0; a < 256; a++) begin
      wr(1, a, pat_ram(a), 1'b0); ram_m[a] = pat_ram(a);
    end
    for (int a = 0; a < 256; a++) begin
      rd(1, a); check("R4 indirect", rd_data, ram_m[a]);
    end
    // R2: direct low half sees the same RAM
    for (int a = 0; a < 128; a++) begin
      rd(0, a); check("R2 direct low", rd_data, ram_m[a]);
    end

    // R3/R9: direct writes across the upper half
    for (int a = 128; a < 256; a++) begin
      wr(0, a, pat_sfr(a), 1'b0);
      if (impl(a)) sfr_m[a] = pat_sfr(a);
    end
    for (int a = 128; a < 256; a++) begin
      rd(0, a);
      if (impl(a)) check("R3 sfr", rd_data, sfr_m[a]);
      else         check("R9 unimpl", rd_data, 8'h00);
      rd(1, a); check("R3 ram untouched", rd_data, ram_m[a]);
    end

    // R2: direct writes to low half visible indirectly
    for (int a = 0; a < 128; a++) begin
      wr(0, a, 8'(a ^ 8'hC3), 1'b0); ram_m[a] = 8'(a ^ 8'hC3);
    end
    for (int a = 0; a < 128; a++) begin
      rd(1, a); check("R2 direct write", rd_data, ram_m[a]);
    end

    // R5/R6/R7/R8: every bit address, read then invert
    for (int ba = 0; ba < 256; ba++) begin
      int t; int b; bit is_ram; logic [7:0] exp;
      b = ba % 8;
      is_ram = (ba < 128);
      t = is_ram ? (32 + ba / 8) : (ba / 8) * 8;
      exp = is_ram ? ram_m[t] : (impl(t) ? sfr_m[t] : 8'h00);
      rd(2, ba);
      check(is_ram ? "R6 bit byte" : "R8 bit byte", rd_data, exp);
      check("R5 bit value", {7'b0, rd_bit}, {7'b0, exp[b]});
      wr(2, ba, 8'hFF, ~exp[b]);
      if (is_ram)      ram_m[t][b] = ~ram_m[t][b];
      else if (impl(t)) sfr_m[t][b] = ~sfr_m[t][b];
      if (is_ram) begin
        rd(1, t); check("R7 ram bit write", rd_data, ram_m[t]);
      end else begin
        rd(0, t); check(impl(t) ? "R7 sfr bit write" : "R9 bit unimpl", rd_data,
                        impl(t) ? sfr_m[t] : 8'h00);
      end
    end
    // R6: RAM outside the bit window kept its pattern
    rd(1, 8'h1F); check("R6 below window", rd_data, ram_m[31]);
    rd(1, 8'h30); check("R6 above window", rd_data, ram_m[48]);

    // R11: reserved mode
    for (int a = 0; a < 256; a += 17) begin
      rd(3, a);
      check("R11 read", rd_data, 8'h00);
      check("R11 bit", {7'b0, rd_bit}, 8'h00);
      wr(3, a, 8'hA5, 1'b1);
      rd(1, a); check("R11 ram kept", rd_data, ram_m[a]);
      if (a >= 128) begin
        rd(0, a); check("R11 sfr kept", rd_data, impl(a) ? sfr_m[a] : 8'h00);
      end
    end

    // R10: write lands at the edge, not before
    @(negedge clk);
    acc_mode = 2'd0; acc_addr = 8'hF0; wr_data = 8'h3C; wr_en = 1'b1;
    #1 check("R10 before edge", rd_data, sfr_m[240]);
    @(posedge clk);
    #1 wr_en = 1'b0; sfr_m[240] = 8'h3C;
    check("R10 after edge", rd_data, 8'h3C);

    // R10: synchronous reset clears the registers
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    for (int a = 128; a < 256; a++) begin
      rd(0, a); check("R10 second reset", rd_data, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule